// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt lines onto sixteen inputs of a legacy interrupt controller. Each of the four lines has its own route byte. A value from 0 to 15 selects the target controller input. Any value of 16 or more turns the line off. Several lines may land on one controller input, and that input is then the logical OR of all of them.

Routing state is kept as a matrix of line-by-target level bits. A write to any route byte clears the matrix and refills it from the present line levels, in the same clock edge that stores the new bytes. Between route writes, a level change on one line touches only that line's own matrix bit.

Each line's route is also shown on a status output, as an enable flag and a 4-bit target. A small combinational helper tells platform logic which of the four lines a device's INTx pin reaches. The line is worked out from the device/function number and the pin.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte reads 0x80, every route status enable is 0 with target 0, and all sixteen controller outputs are low.
- R2: The route bytes form one 32-bit word at byte address 0x60. Byte lane 0 (bits 7:0) is line A, lane 1 is B, lane 2 is C and lane 3 is D. A write with `cfg_be` bit i set stores lane i. Writes to any other word address leave every route byte unchanged. `cfg_rdata` returns the four stored bytes while `cfg_addr` selects word 0x60, and zero otherwise.
- R3: A route byte of 16 or more disables its line. The line's level then has no effect on any output, and its status reports enable 0 and target 0.
- R4: For a route byte below 16, the status shows enable 1 and the target in `route_irq[4*i+3:4*i]`, which equals the low four bits of the byte.
- R5: Controller output n is high when at least one enabled line routed to n is high. It is low when no such line is high.
- R6: When a route write stores new bytes, the outputs seen after that clock edge follow the new routes and the current line levels. The previous target of a moved line drops unless another high line still drives it.
- R7: A line level sampled at a rising edge shows on the outputs immediately after that same edge: one register stage.
- R8: `slot_pirq` equals (`slot_intx` + `slot_devfn[7:3]` - 1) mod 4. Here `slot_intx` 0 to 3 means INTA to INTD, and the result 0 to 3 means line A to D.
- R9: A write with only some byte enables set leaves the route bytes of the unenabled lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (word selected by bits 7:2) |
| cfg_be | input | 4 | Byte enables, one per route byte |
| cfg_wdata | input | 32 | Write data, lane i for line i |
| cfg_rdata | output | 32 | Stored route bytes when the route word is addressed |
| pirq_lvl | input | 4 | Active-high synchronous levels of lines A..D |
| irq_out | output | 16 | Registered levels toward the interrupt controller |
| route_en | output | 4 | Per-line route enabled flag |
| route_irq | output | 16 | Per-line target input, 4 bits per line |
| slot_devfn | input | 8 | Device/function number for the helper |
| slot_intx | input | 2 | INTx pin for the helper (0 = INTA) |
| slot_pirq | output | 2 | Line reached by that pin |

## Verification
Lines are driven one at a time, so each output bit can be tied to a single route. Two lines are then routed to one target so that sharing shows up as an OR rather than a last-writer result. A disabled line is driven high, once with the byte at exactly 16 and once with 0x8F, to show that the enable boundary sits at 16. Routes are rewritten while a line is held high, which shows whether the matrix is rebuilt or keeps a stale bit at the old target. Partial byte-enable writes and writes to a neighbouring word show whether lanes are kept apart and whether the address is decoded.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int DEF_NUM_PIRQ = 4;
  localparam int DEF_NUM_IRQ  = 16;
  localparam int ROUTE_W      = 8;
  localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;
  localparam logic [7:0] ROUTE_BASE = 8'h60;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = DEF_NUM_PIRQ,
  parameter int ADDR_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_PIRQ-1:0]               be,
  input  logic [NUM_PIRQ*ROUTE_W-1:0]       wdata,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_q,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_d,
  output logic                              hit,
  output logic [NUM_PIRQ*ROUTE_W-1:0]       rdata
);
  localparam int ALIGN = $clog2(NUM_PIRQ);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ROUTE_BASE);

  logic sel;

  assign sel = (addr[ADDR_W-1:ALIGN] == BASE[ADDR_W-1:ALIGN]);
  assign hit = wr_en && sel && (|be);

  always_comb begin
    route_d = route_q;
    for (int i = 0; i < NUM_PIRQ; i++) begin
      if (hit && be[i]) route_d[i] = wdata[i*ROUTE_W +: ROUTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= {NUM_PIRQ{ROUTE_RESET}};
    end else if (hit) begin
      route_q <= route_d;
    end
  end

  assign rdata = sel ? route_q : '0;

  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(route_q)) else $error("route changed without write"); // R2
endmodule

// File: rtl/pirq_level_matrix.sv
module pirq_level_matrix
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = DEF_NUM_PIRQ,
  parameter int NUM_IRQ  = DEF_NUM_IRQ
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rebuild,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route,
  input  logic [NUM_PIRQ-1:0]               pirq_lvl,
  output logic [NUM_IRQ-1:0]                irq_q
);
  localparam int IRQ_W = $clog2(NUM_IRQ);
  localparam int CELLS = NUM_PIRQ * NUM_IRQ;

  logic [CELLS-1:0]    mat_q, mat_d;
  logic [NUM_IRQ-1:0]  irq_d;
  logic [NUM_PIRQ-1:0] en;
  logic [NUM_PIRQ-1:0][IRQ_W-1:0] tgt;

  always_comb begin
    for (int p = 0; p < NUM_PIRQ; p++) begin
      en[p]  = (route[p] < ROUTE_W'(NUM_IRQ));
      tgt[p] = route[p][IRQ_W-1:0];
    end
  end

  always_comb begin
    mat_d = rebuild ? '0 : mat_q;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (en[p]) mat_d[int'(tgt[p]) * NUM_PIRQ + p] = pirq_lvl[p];
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_IRQ; n++) irq_d[n] = |mat_d[n*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mat_q <= '0;
      irq_q <= '0;
    end else begin
      mat_q <= mat_d;
      irq_q <= irq_d;
    end
  end

  genvar gp, gn;
  generate
    for (gp = 0; gp < NUM_PIRQ; gp++) begin : g_col
      logic [NUM_IRQ-1:0] col;
      for (gn = 0; gn < NUM_IRQ; gn++) begin : g_bit
        assign col[gn] = mat_q[gn*NUM_PIRQ + gp];
      end
      AST_COLUMN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col) <= 1) else $error("line mapped twice"); // R6
      AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en[gp] |=> (col == '0)) else $error("disabled line left a bit"); // R3
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (en[gp] && pirq_lvl[gp]) |=> irq_q[$past(tgt[gp])]) else $error("level lost"); // R7
    end
    for (gn = 0; gn < NUM_IRQ; gn++) begin : g_row
      AST_OUTPUT_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[gn] == (|mat_q[gn*NUM_PIRQ +: NUM_PIRQ])) else $error("output mismatch"); // R5
    end
  endgenerate
endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
  parameter int NUM_PIRQ = 4
) (
  input  logic [7:0]                  devfn,
  input  logic [$clog2(NUM_PIRQ)-1:0] intx,
  output logic [$clog2(NUM_PIRQ)-1:0] pirq
);
  localparam int PW = $clog2(NUM_PIRQ);
  logic [PW-1:0] slot_lo;

  assign slot_lo = devfn[3 +: PW];
  assign pirq    = slot_lo + intx - PW'(1);
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = DEF_NUM_PIRQ,
  parameter int NUM_IRQ  = DEF_NUM_IRQ,
  parameter int IRQ_W    = $clog2(NUM_IRQ),
  parameter int PIRQ_W   = $clog2(NUM_PIRQ)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_en,
  input  logic [7:0]                  cfg_addr,
  input  logic [NUM_PIRQ-1:0]         cfg_be,
  input  logic [NUM_PIRQ*ROUTE_W-1:0] cfg_wdata,
  output logic [NUM_PIRQ*ROUTE_W-1:0] cfg_rdata,
  input  logic [NUM_PIRQ-1:0]         pirq_lvl,
  output logic [NUM_IRQ-1:0]          irq_out,
  output logic [NUM_PIRQ-1:0]         route_en,
  output logic [NUM_PIRQ*IRQ_W-1:0]   route_irq,
  input  logic [7:0]                  slot_devfn,
  input  logic [PIRQ_W-1:0]           slot_intx,
  output logic [PIRQ_W-1:0]           slot_pirq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q, route_d;
  logic       route_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(8)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .be(cfg_be), .wdata(cfg_wdata), .route_q(route_q), .route_d(route_d),
    .hit(route_hit), .rdata(cfg_rdata)
  );

  pirq_level_matrix #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_matrix (
    .clk(clk), .rst_n(rst_sync_n), .rebuild(route_hit), .route(route_d),
    .pirq_lvl(pirq_lvl), .irq_q(irq_out)
  );

  pirq_slot_map #(.NUM_PIRQ(NUM_PIRQ)) u_slot (
    .devfn(slot_devfn), .intx(slot_intx), .pirq(slot_pirq)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PIRQ; gp++) begin : g_status
      assign route_en[gp] = (route_q[gp] < ROUTE_W'(NUM_IRQ));
      assign route_irq[gp*IRQ_W +: IRQ_W] = route_en[gp] ? route_q[gp][IRQ_W-1:0] : '0;
      AST_STATUS_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !route_en[gp] |-> (route_irq[gp*IRQ_W +: IRQ_W] == '0)) else $error("status target"); // R3
    end
  endgenerate
endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  typedef struct {
    int          kind;
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_lvl;
  logic [15:0] irq_out;
  logic [3:0]  route_en;
  logic [15:0] route_irq;
  logic [7:0]  slot_devfn;
  logic [1:0]  slot_intx;
  logic [1:0]  slot_pirq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  item_t q[$];
  logic [7:0] m_route [4];

  always #2 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pirq_lvl(pirq_lvl), .irq_out(irq_out), .route_en(route_en),
    .route_irq(route_irq), .slot_devfn(slot_devfn), .slot_intx(slot_intx),
    .slot_pirq(slot_pirq)
  );

  function automatic logic [15:0] model_irq(input logic [3:0] lvl);
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++)
      if (m_route[p] < 8'd16 && lvl[p]) r[m_route[p][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [19:0] model_status();
    logic [19:0] r = '0;
    for (int p = 0; p < 4; p++)
      if (m_route[p] < 8'd16) begin
        r[16+p] = 1'b1;
        r[p*4 +: 4] = m_route[p][3:0];
      end
    return r;
  endfunction

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.due = cyc + 1; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // driver: applies one cycle of stimulus and queues what must follow the next edge
  task automatic step(input bit wr, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [3:0] lvl, input string tag,
                      input bit chk_rd, input logic [31:0] exp_rd);
    @(negedge clk);
    cfg_wr_en = wr; cfg_addr = a; cfg_be = be; cfg_wdata = d; pirq_lvl = lvl;
    if (wr && a[7:2] == 6'h18)
      for (int i = 0; i < 4; i++) if (be[i]) m_route[i] = d[i*8 +: 8];
    push(0, {16'h0, model_irq(lvl)}, tag);
    push(1, {12'h0, model_status()}, tag);
    if (chk_rd) push(2, exp_rd, tag);
  endtask

  task automatic slot_chk(input logic [7:0] devfn, input logic [1:0] intx,
                          input logic [1:0] exp, input string tag);
    @(negedge clk);
    slot_devfn = devfn; slot_intx = intx;
    push(3, {30'h0, exp}, tag);
  endtask

  // monitor: compares queued expectations just after each rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {16'h0, irq_out};
        1: act = {12'h0, route_en, route_irq};
        2: act = cfg_rdata;
        default: act = {30'h0, slot_pirq};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
    rst_n = 1'b0; cfg_wr_en = 0; cfg_addr = 8'h60; cfg_be = 0; cfg_wdata = 0;
    pirq_lvl = 0; slot_devfn = 0; slot_intx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    step(0, 8'h60, 4'h0, 0, 4'h0, "R1 reset", 1, 32'h80808080);
    // R3 all lines disabled, levels high
    step(0, 8'h60, 4'h0, 0, 4'hF, "R3 disabled after reset", 0, 0);
    // R2 R4 R6 full write while levels held high: A=5 B=5 C=9 D=0x8F
    step(1, 8'h60, 4'hF, 32'h8F090505, 4'hF, "R6 R2 R4 rebuild", 1, 32'h8F090505);
    step(0, 8'h60, 4'h0, 0, 4'b0001, "R5 R7 line A alone", 0, 0);
    step(0, 8'h60, 4'h0, 0, 4'b0010, "R5 line B shares target", 0, 0);
    step(0, 8'h60, 4'h0, 0, 4'b0011, "R5 shared OR", 0, 0);
    step(0, 8'h60, 4'h0, 0, 4'b1000, "R3 disabled 0x8F ignored", 0, 0);
    step(0, 8'h60, 4'h0, 0, 4'b0100, "R7 line C", 0, 0);
    // R9 partial enable: B -> 12
    step(1, 8'h60, 4'b0010, 32'hFFFF0CFF, 4'b0011, "R9 R6 partial write", 1, 32'h8F090C05);
    // R2 other word ignored
    step(1, 8'h64, 4'hF, 32'h01010101, 4'b0011, "R2 other word", 1, 32'h0);
    step(0, 8'h60, 4'h0, 0, 4'b0011, "R2 unchanged readback", 1, 32'h8F090C05);
    // R3 boundary 16 disabled, 15 enabled
    step(1, 8'h61, 4'b1100, 32'h100F0000, 4'b1100, "R3 R4 boundary 16/15", 1, 32'h100F0C05);
    step(0, 8'h60, 4'h0, 0, 4'b1000, "R3 value 16 disabled", 0, 0);
    // R6 move line A from 5 to 3 while high
    step(0, 8'h60, 4'h0, 0, 4'b0001, "R6 before move", 0, 0);
    step(1, 8'h60, 4'b0001, 32'h00000003, 4'b0001, "R6 move drops old target", 1, 32'h100F0C03);
    step(0, 8'h60, 4'h0, 0, 4'b0000, "R7 all low", 0, 0);
    // R4 enable line D at 0
    step(1, 8'h60, 4'b1000, 32'h00000000, 4'b1001, "R4 target zero", 1, 32'h000F0C03);
    step(0, 8'h60, 4'h0, 0, 4'b0000, "R5 idle", 0, 0);
    // R8 helper
    slot_chk(8'h08, 2'd0, 2'd0, "R8 slot1 INTA");
    slot_chk(8'h00, 2'd0, 2'd3, "R8 slot0 wraps");
    slot_chk(8'h30, 2'd3, 2'd0, "R8 slot6 INTD");
    slot_chk(8'h10, 2'd1, 2'd2, "R8 slot2 INTB");
    slot_chk(8'hFD, 2'd2, 2'd0, "R8 slot31 INTC");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule